// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block collects hardware interrupt requests and presents one interrupt line to a processor. It is built from two eight-input priority stages. The secondary stage, which serves lines 8 to 15, resolves its own winner and feeds that single request into input 2 of the primary stage. The primary stage serves lines 0, 1 and 3 to 7. This leaves fifteen usable request lines. Because of where the cascade enters, the whole secondary group ranks between line 1 and line 3.

Each line has a mask bit and a trigger select. An edge line latches a request when it goes from low to high, and that request stays pending until it is acknowledged. A level line requests for as long as it is held high, so several sources can share it. When the processor acknowledges, the block returns a vector number for the winning line and marks that line in service. The line stays in service until an end-of-interrupt clears it. A line on the secondary stage also marks primary input 2 in service, so software must issue two end-of-interrupts for it.

Top module: `cascaded_pic`

## Requirements
- R1: Input line 2 is never a request source. Driving `irq_in[2]` high in either trigger mode leaves `int_out` low and produces no vector.
- R2: The fixed priority from highest to lowest is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R3: With `edge_mode[n]`=1, a 0-to-1 change on `irq_in[n]` latches a request. An acknowledge clears it. Holding the line high afterwards raises no new request.
- R4: With `edge_mode[n]`=0, line n requests exactly while `irq_in[n]` is high. Dropping the line before the acknowledge withdraws the request.
- R5: A line with `irq_mask[n]`=1 takes no part in arbitration. An edge that arrives while the line is masked is still latched, and it is served once the mask is cleared.
- R6: An acknowledge (`ack` high at a clock edge while `int_out` is high) sets `vector_valid` for one cycle from the next edge. The vector is `prim_base`+n for a primary line n, or `sec_base`+(n-8) for a secondary line n. The acknowledge sets the winner's in-service bit. An acknowledge while `int_out` is low gives no vector.
- R7: An in-service line blocks requests of equal or lower priority within its stage. A request of higher priority still raises `int_out`.
- R8: Acknowledging a secondary line sets both its own in-service bit and that of primary input 2. While input 2 is in service, no secondary line and no line 3 to 7 can interrupt.
- R9: A pulse on `eoi` clears the in-service bit chosen by `eoi_line` (values 0 to 15) at that clock edge.
- R10: After reset, `int_out` and `vector_valid` are low and no line is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; bit 2 is unused |
| irq_mask | input | 16 | Per-line mask, 1 = excluded |
| edge_mode | input | 16 | Per-line trigger, 1 = edge, 0 = level |
| prim_base | input | VEC_W | Vector base for lines 0 to 7 |
| sec_base | input | VEC_W | Vector base for lines 8 to 15 |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe |
| vector_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vector_out | output | VEC_W | Vector number of the acknowledged line |
| eoi | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 4 | Line whose in-service bit is cleared |

## Verification
The bench goes after the places where a plain numeric priority would be wrong. If the design ranked lines by number alone, line 3 would beat line 9. If it dropped the second in-service bit, lines 3 to 7 would interrupt while a secondary handler is still running. A design that gated edge latching by the mask would lose requests that arrive while a line is masked. A design that re-armed edge lines from their level would fire again on a line that is held high. Random runs mix trigger modes, masks, overlapping acknowledges and end-of-interrupts. They compare every `int_out` cycle and every vector against a stage-by-stage model of the requirements.

// File: rtl/cascaded_pic.sv
module cascaded_pic #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      irq_in,
  input  logic [15:0]      irq_mask,
  input  logic [15:0]      edge_mode,
  input  logic [VEC_W-1:0] prim_base,
  input  logic [VEC_W-1:0] sec_base,
  output logic             int_out,
  input  logic             ack,
  output logic             vector_valid,
  output logic [VEC_W-1:0] vector_out,
  input  logic             eoi,
  input  logic [3:0]       eoi_line
);

  localparam logic [15:0] USABLE = 16'hFFFB;

  logic [15:0] prev_q, edge_q, isr_q;
  logic [15:0] pend, elig, win_bit, eoi_clr, isr_set;
  logic [7:0]  p_in, s_upto, p_upto;
  logic [2:0]  s_idx, p_idx;
  logic        s_hit, s_blk, p_hit, p_blk, win_sec, take;
  logic [3:0]  win_line;

  assign pend = (edge_mode & edge_q) | (~edge_mode & irq_in);
  assign elig = pend & ~irq_mask & USABLE;

  always_comb begin
    s_hit = 1'b0;
    s_idx = '0;
    for (int i = 7; i >= 0; i--)
      if (elig[8+i]) begin
        s_hit = 1'b1;
        s_idx = 3'(i);
      end
  end

  assign s_upto = 8'((9'd2 << s_idx) - 9'd1);
  assign s_blk  = |(isr_q[15:8] & s_upto);
  assign p_in   = {elig[7:3], s_hit & ~s_blk, elig[1:0]};

  always_comb begin
    p_hit = 1'b0;
    p_idx = '0;
    for (int i = 7; i >= 0; i--)
      if (p_in[i]) begin
        p_hit = 1'b1;
        p_idx = 3'(i);
      end
  end

  assign p_upto   = 8'((9'd2 << p_idx) - 9'd1);
  assign p_blk    = |(isr_q[7:0] & p_upto);
  assign int_out  = p_hit & ~p_blk;
  assign win_sec  = (p_idx == 3'd2);
  assign win_line = win_sec ? {1'b1, s_idx} : {1'b0, p_idx};
  assign take     = ack & int_out;

  assign win_bit = take ? (16'd1 << win_line) : 16'd0;
  assign isr_set = win_bit | ((take && win_sec) ? 16'h0004 : 16'd0);
  assign eoi_clr = eoi ? (16'd1 << eoi_line) : 16'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q       <= '0;
      edge_q       <= '0;
      isr_q        <= '0;
      vector_valid <= 1'b0;
      vector_out   <= '0;
    end else begin
      prev_q       <= irq_in;
      edge_q       <= (edge_q & ~win_bit) | (irq_in & ~prev_q & edge_mode);
      isr_q        <= (isr_q & ~eoi_clr) | isr_set;
      vector_valid <= take;
      if (take)
        vector_out <= win_sec ? sec_base + VEC_W'(s_idx) : prim_base + VEC_W'(p_idx);
    end
  end

endmodule

// File: rtl/cascaded_pic_chk.sv
module cascaded_pic_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] irq_mask,
  input logic        int_out,
  input logic        ack,
  input logic        vector_valid,
  input logic        eoi,
  input logic [3:0]  eoi_line,
  input logic [15:0] isr_q
);

  a_r5_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !int_out);

  a_r6_valid_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vector_valid |-> $past(ack && int_out));

  a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !eoi) |=> ($countones(isr_q) > $past($countones(isr_q))));

  a_r7_top_line_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[0] |-> !int_out);

  a_r9_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack) |=> !isr_q[$past(eoi_line)]);

endmodule

bind cascaded_pic cascaded_pic_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_mask(irq_mask), .int_out(int_out), .ack(ack),
  .vector_valid(vector_valid), .eoi(eoi), .eoi_line(eoi_line), .isr_q(isr_q)
);

// File: tb/cascaded_pic_tb.sv
module cascaded_pic_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0, msk = '0, esel = '0;
  logic [7:0]  pbase = 8'h20, sbase = 8'h70;
  logic        ack = 1'b0, eoi = 1'b0;
  logic [3:0]  eline = '0;
  logic        int_out, vector_valid;
  logic [7:0]  vector_out;

  int checks = 0, fails = 0;
  logic [15:0] m_prev = '0, m_edge = '0, m_isr = '0;
  logic [4:0]  m_last = '0;

  always #5 clk = ~clk;

  cascaded_pic #(.VEC_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .irq_mask(msk), .edge_mode(esel),
    .prim_base(pbase), .sec_base(sbase), .int_out(int_out), .ack(ack),
    .vector_valid(vector_valid), .vector_out(vector_out), .eoi(eoi), .eoi_line(eline)
  );

  function automatic logic [4:0] m_win(input logic [15:0] el, input logic [15:0] is);
    int s = -1, p = -1;
    logic sreq = 1'b0;
    for (int i = 15; i >= 8; i--) if (el[i]) s = i;
    if (s >= 0) begin
      sreq = 1'b1;
      for (int j = 8; j <= s; j++) if (is[j]) sreq = 1'b0;
    end
    for (int i = 7; i >= 0; i--) if ((i == 2) ? sreq : el[i]) p = i;
    if (p < 0) return '0;
    for (int j = 0; j <= p; j++) if (is[j]) return '0;
    return {1'b1, (p == 2) ? 4'(s) : 4'(p)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic [15:0] el, rise, clr, set;
    logic [4:0]  w;
    logic        exp_vv;
    logic [7:0]  exp_vec;
    #1;
    el = ((esel & m_edge) | (~esel & irq)) & ~msk & 16'hFFFB;
    w = m_win(el, m_isr);
    chk({tag, " int_out (R2)"}, 8'(int_out), 8'(w[4]));
    exp_vv  = ack & w[4];
    exp_vec = w[3] ? sbase + 8'(w[2:0]) : pbase + 8'(w[2:0]);
    if (exp_vv) m_last = w;
    rise = irq & ~m_prev;
    clr  = exp_vv ? (16'd1 << w[3:0]) : 16'd0;
    set  = clr | ((exp_vv && w[3]) ? 16'h0004 : 16'd0);
    m_edge = (m_edge & ~clr) | (rise & esel);
    m_isr  = (m_isr & ~(eoi ? (16'd1 << eline) : 16'd0)) | set;
    m_prev = irq;
    @(posedge clk); #1;
    chk({tag, " vector_valid (R6)"}, 8'(vector_valid), 8'(exp_vv));
    if (exp_vv) chk({tag, " vector (R6)"}, vector_out, exp_vec);
    @(negedge clk);
  endtask

  task automatic do_eoi(input logic [3:0] ln, input string tag);
    eoi = 1'b1; eline = ln; step(tag); eoi = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 int_out in reset", 8'(int_out), 8'd0);
    chk("R10 vector_valid in reset", 8'(vector_valid), 8'd0);
    rst_n = 1'b1;
    step("R10");

    // R1: line 2 in both modes
    irq = 16'h0004; ack = 1'b1; step("R1"); step("R1");
    esel = 16'h0004; irq = 16'h0; step("R1"); irq = 16'h0004; step("R1"); step("R1");
    ack = 1'b0; irq = '0; esel = '0; step("R1");

    // R2: all level lines high, serve one by one
    irq = 16'hFFFB;
    for (int k = 0; k < 15; k++) begin
      ack = 1'b1; step("R2"); ack = 1'b0;
      irq[m_last[3:0]] = 1'b0;
      do_eoi(m_last[3:0], "R9");
      if (m_last[3]) do_eoi(4'd2, "R8");
    end
    step("R2");

    // R3: edge line held high fires once
    esel = 16'hFFFF; irq = 16'h0020; step("R3");
    ack = 1'b1; step("R3"); ack = 1'b0;
    do_eoi(4'd5, "R3"); step("R3"); step("R3");
    irq = '0; step("R3");

    // R4: level request withdrawn
    esel = '0; irq = 16'h0200; step("R4"); irq = '0; ack = 1'b1; step("R4"); ack = 1'b0;

    // R5: masked edge kept and served after unmask
    esel = 16'hFFFF; msk = 16'h0010; irq = 16'h0010; step("R5"); step("R5");
    irq = '0; step("R5"); msk = '0; step("R5");
    ack = 1'b1; step("R5"); ack = 1'b0; do_eoi(4'd4, "R5");

    // R7: preempt by higher, block lower
    esel = '0; irq = 16'h0040; ack = 1'b1; step("R7"); ack = 1'b0;
    irq = 16'h00C0; step("R7");
    irq = 16'h00C8; step("R7"); ack = 1'b1; step("R7"); ack = 1'b0;
    irq = '0; do_eoi(4'd3, "R7"); do_eoi(4'd6, "R7"); step("R7");

    // R8: secondary needs both end-of-interrupts
    irq = 16'h1000; ack = 1'b1; step("R8"); ack = 1'b0;
    irq = 16'h2008; do_eoi(4'd12, "R8"); step("R8");
    do_eoi(4'd2, "R8"); step("R8");
    irq = '0; step("R8");

    // random mix
    void'($urandom(32'd1234));
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    m_prev = '0; m_edge = '0; m_isr = '0; irq = '0;
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) esel = 16'($urandom);
      if (n % 97 == 0) msk = 16'($urandom) & 16'($urandom);
      if (n % 61 == 0) begin pbase = 8'($urandom); sbase = 8'($urandom); end
      irq = irq ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      ack = ($urandom % 3) == 0;
      eoi = ($urandom % 3) == 0;
      eline = 4'($urandom);
      if (m_isr != 0 && ($urandom % 2)) begin
        for (int j = 0; j < 16; j++) if (m_isr[j]) eline = 4'(j);
      end
      step("R2/R7 random");
    end
    ack = 1'b0; eoi = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule